// File: doc/BRIEF.md
# Indexed Block-Access Register Target for a Two-Wire Management Bus

This block is an SMBus target that owns a small bank of 8-bit control registers. A host reaches the bank through two kinds of transfer. Both begin with a starting index, and both move a counted run of bytes while the register index steps forward by itself. SCL and SDA arrive as raw pin levels and are sampled in the system clock domain. Each line is synchronised and glitch-filtered before the block looks for bus conditions. The block pulls SDA low only through an open-drain enable.

In a block write, the host sends the write address, the starting index, a byte count and then the data bytes. In a block read, the host writes the index, issues a repeated START and the read address, and then clocks bytes in. The first byte returned is a count taken from a writable register, and the register contents follow it. Some registers are read-only or partly writable, as set by a per-register write mask. Other logic on the chip observes any register through a combinational look-up port.

Top module: `smbidx_target`

## Requirements
- R1: The 7-bit target address is 0x6E, so the write address byte is 0xDC and the read address byte is 0xDD. The block acknowledges either of these (ACK = SDA low in the ninth bit). Any other address byte is not acknowledged, and the block then ignores the bus, writing nothing, until the next START.
- R2: A block write is made up of the address byte, a starting index N, a byte count X and X data bytes, and the block acknowledges every one of these bytes. Data byte k is stored in register N+k.
- R3: Data bytes that arrive after the X counted bytes are not acknowledged and are not stored.
- R4: In a block read (write address, index N, repeated START, read address), the block first returns the value of register 6 as the count. It then returns registers N, N+1, and so on, MSB first.
- R5: When the host answers a read byte with NACK, the block releases SDA and keeps it released on every later SCL pulse until the next START.
- R6: The index steps from 13 (the last register) back to 0, on both writes and reads.
- R7: A starting index of 14 or more is taken as index 0.
- R8: Writes pass through a per-register mask. Registers 4 and 5 are read-only and hold 0x01 and 0x43. Registers 7 and 8 always read 0x00. Bit 7 of register 13 always reads 0. All other bits are writable.
- R9: After reset, register 4 reads 0x01, register 5 reads 0x43 and register 6 reads 0x07. All other registers read 0x00, and SDA is released.
- R10: A low pulse on SCL that lasts fewer than FILT system clocks is not counted as a clock edge.
- R11: `cfg_q` shows the current contents of the register selected by `cfg_idx`, in the same cycle. It shows 0x00 when the index is out of range.
- R12: The SDA drive changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Raw SCL pin level |
| sda_i | input | 1 | Raw SDA pin level |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| cfg_idx | input | $clog2(NREGS) | Register index for internal look-up |
| cfg_q | output | 8 | Contents of the register at cfg_idx |

## Verification
A wrong internal index or phase shows up at the ports within one byte time. An ACK appears in the wrong ninth bit, a byte lands in the wrong register of the look-up port, or a read byte differs from the register model. A lost bit count shifts every later byte by one position, so the next ACK slot already reads a released SDA. A drive enable left asserted after a host NACK shows up as a low SDA on the very next read pulse. Stale mask logic shows up as a changed read-only value the first time the look-up port reads that register after a write.

// File: rtl/smbidx_pkg.sv
// Package: shared types and the register bank's reset values and write masks.
// Assumes register indices fit in 32 bits; unknown indices default to a plain RW byte.
package smbidx_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_INDEX,
        PH_COUNT,
        PH_WDATA,
        PH_TX,
        PH_SKIP
    } phase_t;

    function automatic logic [7:0] reg_default(int unsigned i);
        case (i)
            4:       return 8'h01;
            5:       return 8'h43;
            6:       return 8'h07;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] reg_wmask(int unsigned i);
        case (i)
            4, 5, 7, 8: return 8'h00;
            13:         return 8'h7F;
            default:    return 8'hFF;
        endcase
    endfunction

endpackage

// File: rtl/smbidx_filter.sv
// Line conditioner: two-flop synchronizer followed by a glitch filter.
// The output follows the input only after FILT consecutive differing samples.
// Assumes the bus idles high, so both stages reset to 1.
module smbidx_filter #(
    parameter int FILT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    localparam int CW = $clog2(FILT + 1);

    logic [1:0]    sync_q;
    logic [CW-1:0] cnt_q;
    logic          lvl_q;

    // Synchronise the asynchronous pin into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= 2'b11;
        else        sync_q <= {sync_q[0], din};
    end

    // Accept a new level only after it has been stable for FILT samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q <= 1'b1;
            cnt_q <= '0;
        end else if (sync_q[1] == lvl_q) begin
            cnt_q <= '0;
        end else if (cnt_q == CW'(FILT - 1)) begin
            lvl_q <= sync_q[1];
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign dout = lvl_q;
endmodule

// File: rtl/smbidx_regfile.sv
// Register bank: NREGS bytes, each with a reset value and a write mask from the package.
// Bits whose mask is 0 keep their reset value for ever. One write port; all contents flat out.
module smbidx_regfile
    import smbidx_pkg::*;
#(
    parameter int NREGS = 14,
    parameter int IDX_W = $clog2(NREGS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [IDX_W-1:0]   waddr,
    input  logic [7:0]         wdata,
    output logic [NREGS*8-1:0] regs_flat
);
    for (genvar i = 0; i < NREGS; i++) begin : g_reg
        localparam logic [7:0] DEF  = reg_default(i);
        localparam logic [7:0] MASK = reg_wmask(i);
        logic [7:0] q;

        // Hold the byte; merge writable bits on a matching write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                q <= DEF;
            else if (we && waddr == IDX_W'(i))
                q <= (q & ~MASK) | (wdata & MASK);
        end

        assign regs_flat[i*8 +: 8] = q;
    end
endmodule

// File: rtl/smbidx_engine.sv
// Bus engine: detects START/STOP on the filtered lines and runs the address,
// index, count, write-data and read-data phases. It drives ACK and read bits through sda_oe.
// Assumes SCL and SDA are already synchronous and filtered, and that the bus idles high.
module smbidx_engine
    import smbidx_pkg::*;
#(
    parameter logic [6:0] ADDR7 = 7'h6E,
    parameter int         NREGS = 14,
    parameter int         IDX_W = $clog2(NREGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_f,
    input  logic             sda_f,
    input  logic [7:0]       rd_data,
    input  logic [7:0]       cnt_val,
    output logic             sda_oe,
    output logic             we,
    output logic [IDX_W-1:0] idx,
    output logic [7:0]       wdata,
    output phase_t           phase,
    output logic [3:0]       bitcnt
);
    logic scl_d, sda_d;
    logic scl_rise, scl_fall, start_c, stop_c;

    phase_t           phase_q, nxt_q;
    logic [3:0]       bitcnt_q;
    logic [7:0]       sh_q;
    logic [7:0]       left_q;
    logic [IDX_W-1:0] idx_q;
    logic             oe_q;

    function automatic logic [IDX_W-1:0] idx_inc(input logic [IDX_W-1:0] v);
        return (v == IDX_W'(NREGS - 1)) ? '0 : v + 1'b1;
    endfunction

    // Keep the previous line levels for edge and bus-condition detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_f;
            sda_d <= sda_f;
        end
    end

    assign scl_rise = scl_f & ~scl_d;
    assign scl_fall = ~scl_f & scl_d;
    assign start_c  = scl_f & scl_d & sda_d & ~sda_f;
    assign stop_c   = scl_f & scl_d & ~sda_d & sda_f;

    // Register write strobe: end of a counted data byte in the write phase.
    assign we    = (phase_q == PH_WDATA) && scl_fall && (bitcnt_q == 4'd8) && (left_q != 8'd0);
    assign wdata = sh_q;

    // Transaction sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q  <= PH_IDLE;
            nxt_q    <= PH_IDLE;
            bitcnt_q <= '0;
            sh_q     <= '0;
            left_q   <= '0;
            idx_q    <= '0;
            oe_q     <= 1'b0;
        end else if (start_c) begin
            phase_q  <= PH_ADDR;
            bitcnt_q <= '0;
            oe_q     <= 1'b0;
        end else if (stop_c) begin
            phase_q  <= PH_IDLE;
            bitcnt_q <= '0;
            oe_q     <= 1'b0;
        end else begin
            case (phase_q)
                PH_IDLE, PH_SKIP: ;
                PH_TX: begin
                    if (scl_rise && bitcnt_q == 4'd9 && sda_f) begin
                        phase_q <= PH_SKIP;
                    end else if (scl_fall) begin
                        if (bitcnt_q == 4'd9) begin
                            oe_q     <= ~rd_data[7];
                            sh_q     <= {rd_data[6:0], 1'b0};
                            idx_q    <= idx_inc(idx_q);
                            bitcnt_q <= 4'd1;
                        end else if (bitcnt_q == 4'd8) begin
                            oe_q     <= 1'b0;
                            bitcnt_q <= 4'd9;
                        end else begin
                            oe_q     <= ~sh_q[7];
                            sh_q     <= {sh_q[6:0], 1'b0};
                            bitcnt_q <= bitcnt_q + 1'b1;
                        end
                    end
                end
                default: begin
                    if (scl_rise && bitcnt_q < 4'd8) begin
                        sh_q     <= {sh_q[6:0], sda_f};
                        bitcnt_q <= bitcnt_q + 1'b1;
                    end else if (scl_fall && bitcnt_q == 4'd8) begin
                        bitcnt_q <= 4'd9;
                        case (phase_q)
                            PH_ADDR: begin
                                if (sh_q[7:1] == ADDR7) begin
                                    oe_q  <= 1'b1;
                                    nxt_q <= sh_q[0] ? PH_TX : PH_INDEX;
                                end else begin
                                    phase_q <= PH_SKIP;
                                end
                            end
                            PH_INDEX: begin
                                oe_q  <= 1'b1;
                                idx_q <= (sh_q < 8'(NREGS)) ? sh_q[IDX_W-1:0] : '0;
                                nxt_q <= PH_COUNT;
                            end
                            PH_COUNT: begin
                                oe_q   <= 1'b1;
                                left_q <= sh_q;
                                nxt_q  <= PH_WDATA;
                            end
                            default: begin
                                if (left_q != 8'd0) begin
                                    oe_q   <= 1'b1;
                                    left_q <= left_q - 1'b1;
                                    idx_q  <= idx_inc(idx_q);
                                    nxt_q  <= PH_WDATA;
                                end else begin
                                    phase_q <= PH_SKIP;
                                end
                            end
                        endcase
                    end else if (scl_fall && bitcnt_q == 4'd9) begin
                        phase_q  <= nxt_q;
                        bitcnt_q <= '0;
                        oe_q     <= 1'b0;
                        if (nxt_q == PH_TX) begin
                            oe_q     <= ~cnt_val[7];
                            sh_q     <= {cnt_val[6:0], 1'b0};
                            bitcnt_q <= 4'd1;
                        end
                    end
                end
            endcase
        end
    end

    assign sda_oe = oe_q;
    assign idx    = idx_q;
    assign phase  = phase_q;
    assign bitcnt = bitcnt_q;
endmodule

// File: rtl/smbidx_target.sv
// Top: conditions both bus lines, runs the engine and holds the register bank.
// The register at CNT_IDX supplies the count byte of a block read.
// Assumes clk is at least several times faster than SCL.
module smbidx_target #(
    parameter logic [6:0] ADDR7   = 7'h6E,
    parameter int         NREGS   = 14,
    parameter int         CNT_IDX = 6,
    parameter int         FILT    = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       scl_i,
    input  logic                       sda_i,
    output logic                       sda_oe,
    input  logic [$clog2(NREGS)-1:0]   cfg_idx,
    output logic [7:0]                 cfg_q
);
    import smbidx_pkg::*;
    localparam int IDX_W = $clog2(NREGS);

    logic [1:0]         raw, filt;
    logic               scl_f, sda_f;
    logic               we;
    logic [IDX_W-1:0]   idx;
    logic [7:0]         wdata, rd_data, cnt_val;
    logic [NREGS*8-1:0] regs_flat;
    logic [7:0]         reg_arr [NREGS];
    phase_t             phase;
    logic [3:0]         bitcnt;

    assign raw = {scl_i, sda_i};

    for (genvar l = 0; l < 2; l++) begin : g_line
        smbidx_filter #(.FILT(FILT)) u_filt (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (raw[l]),
            .dout (filt[l])
        );
    end

    assign scl_f = filt[1];
    assign sda_f = filt[0];

    for (genvar i = 0; i < NREGS; i++) begin : g_unpack
        assign reg_arr[i] = regs_flat[i*8 +: 8];
    end

    assign rd_data = (idx < IDX_W'(NREGS)) ? reg_arr[idx] : 8'h00;
    assign cnt_val = reg_arr[CNT_IDX];
    assign cfg_q   = (cfg_idx < IDX_W'(NREGS)) ? reg_arr[cfg_idx] : 8'h00;

    smbidx_engine #(
        .ADDR7(ADDR7),
        .NREGS(NREGS),
        .IDX_W(IDX_W)
    ) u_engine (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_f  (scl_f),
        .sda_f  (sda_f),
        .rd_data(rd_data),
        .cnt_val(cnt_val),
        .sda_oe (sda_oe),
        .we     (we),
        .idx    (idx),
        .wdata  (wdata),
        .phase  (phase),
        .bitcnt (bitcnt)
    );

    smbidx_regfile #(
        .NREGS(NREGS),
        .IDX_W(IDX_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (we),
        .waddr    (idx),
        .wdata    (wdata),
        .regs_flat(regs_flat)
    );
endmodule

// File: rtl/smbidx_target_chk.sv
// Checker: temporal properties of the target, bound into every smbidx_target instance.
module smbidx_target_chk
    import smbidx_pkg::*;
#(
    parameter int NREGS = 14,
    parameter int IDX_W = $clog2(NREGS)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               scl_f,
    input logic               sda_oe,
    input phase_t             phase,
    input logic [3:0]         bitcnt,
    input logic [IDX_W-1:0]   idx,
    input logic [NREGS*8-1:0] regs_flat
);
    // R1 / R5: no drive while idle or ignoring the bus.
    a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE || phase == PH_SKIP) |-> !sda_oe);

    // R5: the host's acknowledge slot of a read byte is left free.
    a_r5_host_slot_free: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_TX && bitcnt == 4'd9) |-> !sda_oe);

    // R6: the index never leaves the implemented register space.
    a_r6_idx_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        idx < IDX_W'(NREGS));

    // R8: the identification registers never change.
    a_r8_id_stable: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($stable(regs_flat[4*8 +: 8]) && $stable(regs_flat[5*8 +: 8])));

    // R12: the drive enable only moves while the filtered SCL is low.
    a_r12_sda_change_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_f);
endmodule

bind smbidx_target smbidx_target_chk #(
    .NREGS(NREGS),
    .IDX_W($clog2(NREGS))
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_f    (scl_f),
    .sda_oe   (sda_oe),
    .phase    (phase),
    .bitcnt   (bitcnt),
    .idx      (idx),
    .regs_flat(regs_flat)
);

// File: tb/smbidx_target_bench.sv
// Directed bench: a bit-level host model, one task per scenario, each checking its own results.
module smbidx_target_bench;
    localparam int NREGS = 14;
    localparam int Q = 10;
    localparam int H = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       host_low = 1'b0;
    logic       sda_i;
    logic       sda_oe;
    logic [3:0] cfg_idx = '0;
    logic [7:0] cfg_q;

    int checks = 0;
    int errors = 0;
    int r12_bad = 0;
    logic oe_prev = 1'b0;

    logic [7:0] exp_regs [NREGS];
    logic [7:0] wbuf [16];
    logic [7:0] rbuf [16];

    always #10 clk = ~clk;

    assign sda_i = ~(host_low | sda_oe);

    smbidx_target u_smbidx_target (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_i  (scl),
        .sda_i  (sda_i),
        .sda_oe (sda_oe),
        .cfg_idx(cfg_idx),
        .cfg_q  (cfg_q)
    );

    // R12 monitor: the drive enable must not move while SCL is high.
    always @(negedge clk) begin
        if (rst_n && sda_oe !== oe_prev && scl === 1'b1) r12_bad++;
        oe_prev = sda_oe;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // ---------------- host bit level ----------------
    task automatic h_start;
        host_low = 1'b0; tick(Q);
        scl = 1'b1;      tick(Q);
        host_low = 1'b1; tick(Q);
        scl = 1'b0;      tick(Q);
    endtask

    task automatic h_stop;
        host_low = 1'b1; tick(Q);
        scl = 1'b1;      tick(Q);
        host_low = 1'b0; tick(H);
    endtask

    task automatic h_wbit(input logic b, input logic glitch);
        host_low = ~b; tick(Q);
        scl = 1'b1;    tick(8);
        if (glitch) scl = 1'b0;
        tick(2);
        scl = 1'b1;    tick(10);
        scl = 1'b0;    tick(Q);
    endtask

    task automatic h_rbit(output logic b);
        host_low = 1'b0; tick(Q);
        scl = 1'b1;      tick(Q);
        b = sda_i;       tick(Q);
        scl = 1'b0;      tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] v, input logic glitch, output logic ack);
        logic b;
        for (int k = 7; k >= 0; k--) h_wbit(v[k], glitch && k == 4);
        h_rbit(b);
        ack = ~b;
    endtask

    task automatic recv_byte(input logic ack, output logic [7:0] v);
        logic b;
        for (int k = 7; k >= 0; k--) begin
            h_rbit(b);
            v[k] = b;
        end
        h_wbit(~ack, 1'b0);
    endtask

    // ---------------- model ----------------
    function automatic logic [7:0] mask_of(input int i);
        if (i == 4 || i == 5 || i == 7 || i == 8) return 8'h00;
        if (i == 13) return 8'h7F;
        return 8'hFF;
    endfunction

    function automatic int nxt_idx(input int i);
        return (i == NREGS - 1) ? 0 : i + 1;
    endfunction

    task automatic model_write(input int start, input int n);
        int i;
        i = (start >= NREGS) ? 0 : start;
        for (int k = 0; k < n; k++) begin
            exp_regs[i] = (exp_regs[i] & ~mask_of(i)) | (wbuf[k] & mask_of(i));
            i = nxt_idx(i);
        end
    endtask

    task automatic check_regs(input string req);
        for (int i = 0; i < NREGS; i++) begin
            cfg_idx = 4'(i);
            tick(1);
            chk(req, {24'h0, cfg_q}, {24'h0, exp_regs[i]});
        end
    endtask

    // Block write: ackv bit 0 address, 1 index, 2 count, 3+k data byte k.
    task automatic blk_write(input logic [7:0] abyte, input logic [7:0] start,
                             input logic [7:0] cnt, input int ndata, input logic glitch,
                             output logic [31:0] ackv);
        logic a;
        ackv = '0;
        h_start;
        send_byte(abyte, 1'b0, a);  ackv[0] = a;
        send_byte(start, glitch, a); ackv[1] = a;
        send_byte(cnt, glitch, a);   ackv[2] = a;
        for (int k = 0; k < ndata; k++) begin
            send_byte(wbuf[k], glitch, a);
            ackv[3+k] = a;
        end
        h_stop;
    endtask

    // Block read: ackv bit 0 write address, 1 index, 2 read address.
    task automatic blk_read(input logic [7:0] start, input int nrd,
                            output logic [7:0] cnt_rx, output logic [31:0] ackv,
                            output int low_after_nack);
        logic a, b;
        ackv = '0;
        low_after_nack = 0;
        h_start;
        send_byte(8'hDC, 1'b0, a); ackv[0] = a;
        send_byte(start, 1'b0, a); ackv[1] = a;
        h_start;
        send_byte(8'hDD, 1'b0, a); ackv[2] = a;
        recv_byte(1'b1, cnt_rx);
        for (int k = 0; k < nrd; k++) recv_byte(k != nrd - 1, rbuf[k]);
        for (int k = 0; k < 9; k++) begin
            h_rbit(b);
            if (b == 1'b0) low_after_nack++;
        end
        h_stop;
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset;
        for (int i = 0; i < NREGS; i++) exp_regs[i] = 8'h00;
        exp_regs[4] = 8'h01; exp_regs[5] = 8'h43; exp_regs[6] = 8'h07;
        chk("R9 sda released after reset", {31'h0, sda_oe}, 32'h0);
        check_regs("R9 R11 reset contents");
        cfg_idx = 4'd14;
        tick(1);
        chk("R11 out-of-range look-up", {24'h0, cfg_q}, 32'h0);
    endtask

    task automatic t_write_basic;
        logic [31:0] ackv;
        wbuf[0] = 8'hA5; wbuf[1] = 8'h3C; wbuf[2] = 8'hF0;
        blk_write(8'hDC, 8'd0, 8'd3, 3, 1'b0, ackv);
        chk("R2 all bytes acknowledged", ackv, 32'h3F);
        model_write(0, 3);
        check_regs("R2 R11 block write contents");
    endtask

    task automatic t_write_masked;
        logic [31:0] ackv;
        wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
        wbuf[3] = 8'h05; wbuf[4] = 8'h55; wbuf[5] = 8'h66;
        blk_write(8'hDC, 8'd3, 8'd6, 6, 1'b0, ackv);
        chk("R8 read-only bytes still acknowledged", ackv, 32'h1FF);
        model_write(3, 6);
        check_regs("R8 masked write contents");
    endtask

    task automatic t_wrap_write;
        logic [31:0] ackv;
        wbuf[0] = 8'hFF; wbuf[1] = 8'hFF; wbuf[2] = 8'h99;
        blk_write(8'hDC, 8'd12, 8'd3, 3, 1'b0, ackv);
        chk("R6 wrapping write acknowledged", ackv, 32'h3F);
        model_write(12, 3);
        check_regs("R6 R8 wrap and reg13 bit7");
    endtask

    task automatic t_extra_bytes;
        logic [31:0] ackv;
        wbuf[0] = 8'h01; wbuf[1] = 8'h02; wbuf[2] = 8'h03; wbuf[3] = 8'h04;
        blk_write(8'hDC, 8'd9, 8'd2, 4, 1'b0, ackv);
        chk("R3 bytes beyond count not acknowledged", ackv, 32'h1F);
        model_write(9, 2);
        check_regs("R3 bytes beyond count not stored");
    endtask

    task automatic t_bad_address;
        logic [31:0] ackv;
        wbuf[0] = 8'h77;
        blk_write(8'hD8, 8'd0, 8'd1, 1, 1'b0, ackv);
        chk("R1 foreign address ignored", ackv, 32'h0);
        check_regs("R1 foreign address writes nothing");
        wbuf[0] = 8'h6D;
        blk_write(8'hDC, 8'd1, 8'd1, 1, 1'b0, ackv);
        chk("R1 recovers at next START", ackv, 32'hF);
        model_write(1, 1);
        check_regs("R1 write after recovery");
    endtask

    task automatic t_read(input logic [7:0] start, input logic [7:0] cnt, input string req);
        logic [31:0] ackv;
        logic [7:0]  cnt_rx;
        int          low_n;
        int          i;
        wbuf[0] = cnt;
        blk_write(8'hDC, 8'd6, 8'd1, 1, 1'b0, ackv);
        model_write(6, 1);
        blk_read(start, int'(cnt), cnt_rx, ackv, low_n);
        chk({req, " R1 read addresses acknowledged"}, ackv, 32'h7);
        chk({req, " R4 count byte from register 6"}, {24'h0, cnt_rx}, {24'h0, cnt});
        i = (start >= NREGS) ? 0 : int'(start);
        for (int k = 0; k < int'(cnt); k++) begin
            chk({req, " R4 read data"}, {24'h0, rbuf[k]}, {24'h0, exp_regs[i]});
            i = nxt_idx(i);
        end
        chk({req, " R5 SDA released after host NACK"}, low_n, 0);
    endtask

    task automatic t_out_of_range;
        logic [31:0] ackv;
        wbuf[0] = 8'h5A;
        blk_write(8'hDC, 8'd20, 8'd1, 1, 1'b0, ackv);
        chk("R7 out-of-range index acknowledged", ackv, 32'hF);
        model_write(20, 1);
        check_regs("R7 out-of-range index maps to 0");
    endtask

    task automatic t_glitch;
        logic [31:0] ackv;
        wbuf[0] = 8'hC3; wbuf[1] = 8'h3A;
        blk_write(8'hDC, 8'd2, 8'd2, 2, 1'b1, ackv);
        chk("R10 glitched write acknowledged", ackv, 32'h1F);
        model_write(2, 2);
        check_regs("R10 short SCL pulses not counted");
    endtask

    initial begin
        tick(5);
        rst_n = 1'b1;
        tick(5);
        t_reset;
        t_write_basic;
        t_write_masked;
        t_wrap_write;
        t_extra_bytes;
        t_bad_address;
        t_read(8'd0, 8'd3, "read from 0");
        t_read(8'd12, 8'd4, "R6 read across wrap");
        t_out_of_range;
        t_glitch;
        chk("R12 drive changes only while SCL low", r12_bad, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule